// File: doc/BRIEF.md
# Receive Bit-Clock and Serial Flag Pin Controller

This block owns one bidirectional pad for a serial audio receiver. With the flag role disabled (synchronous mode off), the pad is the receiver bit clock. It is an input or an output depending on one direction bit. An incoming external clock is passed through a synchronizer into the system clock domain. From there the block produces single-cycle rising-edge and falling-edge strobes, and every enabled receiver uses them.

With synchronous mode on, the same pad becomes a serial flag, and the same direction bit picks its sense. As an output, the pad shows a control bit that is registered only at frame-sync strobes. As an input, the synchronized pad level is latched into a status bit. The latch happens at frame sync in normal mode and at each slot strobe in network mode. When the clock and flag functions are disabled, the pad falls back to general-purpose I/O.

An external clock may be asynchronous to the system clock. The system clock must then run at least three times faster, and each external clock phase must last longer than 1.5 system clock periods.

Top module: `rx_clk_flag_pin`

## Requirements
- R1: While rst_ni is low, pad_oe_o is 0. After reset, flag_stat_o is 0, and the output-flag register is 0, so pad_o is 0 in the flag-output role.
- R2: With func_en_i=1, sync_mode_i=0 and dir_out_i=1, pad_oe_o is 1, and both pad_o and rx_bclk_o follow int_bclk_i combinationally.
- R3: With func_en_i=1, sync_mode_i=0 and dir_out_i=0, pad_oe_o is 0, and rx_bclk_o equals pad_i delayed through two system-clock flops.
- R4: In the clock-input role of R3, a 0-to-1 change of pad_i raises bclk_rise_o for exactly one cycle, 2 clock edges after the change. A 1-to-0 change does the same on bclk_fall_o. In every other role both strobes stay 0.
- R5: With func_en_i=1, sync_mode_i=1 and dir_out_i=1, pad_oe_o is 1 and pad_o shows the output-flag register.
- R6: The output-flag register loads flag_ctrl_i at a clock edge where frame_sync_i is 1, and holds its value at every other edge.
- R7: With func_en_i=1, sync_mode_i=1, dir_out_i=0 and net_mode_i=0, pad_oe_o is 0. flag_stat_o loads the synchronized pad level at an edge where frame_sync_i is 1, and slot_strobe_i has no effect on it.
- R8: In the flag-input role with net_mode_i=1, flag_stat_o loads the synchronized pad level at an edge where slot_strobe_i is 1, and frame_sync_i has no effect on it.
- R9: With func_en_i=0, pad_o equals gpio_out_i, pad_oe_o equals gpio_dir_i, and gpio_in_o equals pad_i delayed through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| func_en_i | input | 1 | 1: clock/flag function, 0: GPIO |
| sync_mode_i | input | 1 | 1: serial flag role, 0: bit clock role |
| dir_out_i | input | 1 | 1: pad driven by block, 0: pad is input |
| net_mode_i | input | 1 | 1: flag input sampled at slot strobes |
| frame_sync_i | input | 1 | Frame-sync strobe, system domain |
| slot_strobe_i | input | 1 | Slot-boundary strobe, system domain |
| flag_ctrl_i | input | 1 | Control bit for the output flag |
| int_bclk_i | input | 1 | Internally generated bit clock |
| gpio_out_i | input | 1 | GPIO output value |
| gpio_dir_i | input | 1 | GPIO output enable |
| pad_i | input | 1 | Pad input level |
| pad_o | output | 1 | Pad output level |
| pad_oe_o | output | 1 | Pad output enable |
| rx_bclk_o | output | 1 | Receiver bit clock level, system domain |
| bclk_rise_o | output | 1 | Rising-edge strobe of external clock |
| bclk_fall_o | output | 1 | Falling-edge strobe of external clock |
| flag_stat_o | output | 1 | Input-flag status bit |
| gpio_in_o | output | 1 | Synchronized pad level |

## Verification
The pad multiplexer (R2, R5, R9 and the output enables) has no registers, so the bench checks it in the same half cycle that the inputs change. A registered flag shows up on pad_o after the first clock edge at which frame_sync_i is high, and flag_stat_o changes after the edge of the selected strobe. The pad value that gets captured must have been stable for two edges first, because that is the depth of the synchronizer. rx_bclk_o, gpio_in_o and the edge strobes lag pad_i by two edges. The bench therefore checks a strobe right after the second edge and checks again after the third, to confirm it lasts one cycle.

// File: rtl/rx_clk_flag_pkg.sv
package rx_clk_flag_pkg;
  typedef enum logic [2:0] {
    ROLE_GPIO,
    ROLE_CLK_IN,
    ROLE_CLK_OUT,
    ROLE_FLAG_IN,
    ROLE_FLAG_OUT
  } pin_role_e;

  function automatic pin_role_e decode_role(logic func_en, logic sync_mode, logic dir_out);
    if (!func_en)  return ROLE_GPIO;
    if (sync_mode) return dir_out ? ROLE_FLAG_OUT : ROLE_FLAG_IN;
    return dir_out ? ROLE_CLK_OUT : ROLE_CLK_IN;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pad_i,
  input  logic edge_en_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= pad_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = edge_en_i &  sync_q[STAGES-1] & ~prev_q;
  assign fall_o = edge_en_i & ~sync_q[STAGES-1] &  prev_q;

  // R4
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) rise_o |=> !rise_o);
  // R4
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) fall_o |=> !fall_o);
endmodule

// File: rtl/out_flag_reg.sv
module out_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_sync_i,
  input  logic flag_ctrl_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           flag_o <= 1'b0;
    else if (frame_sync_i) flag_o <= flag_ctrl_i;

  // R6
  of_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !frame_sync_i |=> $stable(flag_o));
  // R6
  of_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) frame_sync_i |=> flag_o == $past(flag_ctrl_i));
endmodule

// File: rtl/in_flag_cap.sv
module in_flag_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic net_mode_i,
  input  logic frame_sync_i,
  input  logic slot_strobe_i,
  input  logic lvl_i,
  output logic stat_o
);
  logic take;
  assign take = cap_en_i & (net_mode_i ? slot_strobe_i : frame_sync_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   stat_o <= 1'b0;
    else if (take) stat_o <= lvl_i;

  // R7
  if_normal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!net_mode_i && !frame_sync_i) |=> $stable(stat_o));
  // R8
  if_net_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_mode_i && !slot_strobe_i) |=> $stable(stat_o));
endmodule

// File: rtl/rx_clk_flag_pin.sv
module rx_clk_flag_pin
  import rx_clk_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic func_en_i,
  input  logic sync_mode_i,
  input  logic dir_out_i,
  input  logic net_mode_i,
  input  logic frame_sync_i,
  input  logic slot_strobe_i,
  input  logic flag_ctrl_i,
  input  logic int_bclk_i,
  input  logic gpio_out_i,
  input  logic gpio_dir_i,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe_o,
  output logic rx_bclk_o,
  output logic bclk_rise_o,
  output logic bclk_fall_o,
  output logic flag_stat_o,
  output logic gpio_in_o
);
  pin_role_e role;
  logic      pad_lvl, of_q;

  assign role = decode_role(func_en_i, sync_mode_i, dir_out_i);

  pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pad_i     (pad_i),
    .edge_en_i (role == ROLE_CLK_IN),
    .lvl_o     (pad_lvl),
    .rise_o    (bclk_rise_o),
    .fall_o    (bclk_fall_o)
  );

  out_flag_reg i_oflag (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_sync_i (frame_sync_i),
    .flag_ctrl_i  (flag_ctrl_i),
    .flag_o       (of_q)
  );

  in_flag_cap i_iflag (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cap_en_i      (role == ROLE_FLAG_IN),
    .net_mode_i    (net_mode_i),
    .frame_sync_i  (frame_sync_i),
    .slot_strobe_i (slot_strobe_i),
    .lvl_i         (pad_lvl),
    .stat_o        (flag_stat_o)
  );

  always_comb begin
    pad_o     = 1'b0;
    pad_oe_o  = 1'b0;
    rx_bclk_o = 1'b0;
    unique case (role)
      ROLE_GPIO:     begin pad_o = gpio_out_i; pad_oe_o = gpio_dir_i; end
      ROLE_CLK_OUT:  begin pad_o = int_bclk_i; pad_oe_o = 1'b1; rx_bclk_o = int_bclk_i; end
      ROLE_CLK_IN:   rx_bclk_o = pad_lvl;
      ROLE_FLAG_OUT: begin pad_o = of_q; pad_oe_o = 1'b1; end
      default:       ;
    endcase
    if (!rst_ni) pad_oe_o = 1'b0; // pin is input in reset
  end

  assign gpio_in_o = pad_lvl;

  // R3
  clk_in_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_en_i && !dir_out_i) |-> !pad_oe_o);
  // R4
  no_strobe_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!func_en_i || sync_mode_i || dir_out_i) |-> !(bclk_rise_o || bclk_fall_o));
  // R5
  flag_out_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_en_i && dir_out_i) |-> pad_oe_o);
endmodule

// File: tb/test_rx_clk_flag_pin.sv
module test_rx_clk_flag_pin;
  logic clk = 1'b0, rst_n = 1'b0;
  logic func_en = 0, sync_mode = 0, dir_out = 0, net_mode = 0, fs = 0, slot = 0;
  logic flag_ctrl = 0, int_bclk = 0, gpio_out = 0, gpio_dir = 0, pad = 0;
  logic pad_o, pad_oe, rx_bclk, rise, fall, stat, gpio_in;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_clk_flag_pin i_rx_clk_flag_pin (
    .clk_i(clk), .rst_ni(rst_n), .func_en_i(func_en), .sync_mode_i(sync_mode),
    .dir_out_i(dir_out), .net_mode_i(net_mode), .frame_sync_i(fs), .slot_strobe_i(slot),
    .flag_ctrl_i(flag_ctrl), .int_bclk_i(int_bclk), .gpio_out_i(gpio_out), .gpio_dir_i(gpio_dir),
    .pad_i(pad), .pad_o(pad_o), .pad_oe_o(pad_oe), .rx_bclk_o(rx_bclk),
    .bclk_rise_o(rise), .bclk_fall_o(fall), .flag_stat_o(stat), .gpio_in_o(gpio_in));

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // {func_en, sync, dir, gpio_out, gpio_dir, int_bclk, exp_oe, exp_pad}
  localparam logic [7:0] VEC [10] = '{
    8'b0_0_0_1_1_0_1_1, // R9
    8'b0_0_0_1_0_0_0_1, // R9
    8'b0_1_1_0_1_1_1_0, // R9
    8'b1_0_1_0_0_1_1_1, // R2
    8'b1_0_1_1_1_0_1_0, // R2
    8'b1_0_0_1_1_1_0_0, // R3
    8'b1_1_1_1_1_1_1_0, // R5 flag reg still 0 (R1)
    8'b1_1_0_1_1_1_0_0, // R7
    8'b0_1_0_0_0_1_0_0, // R9
    8'b1_0_1_0_0_0_1_0  // R2
  };

  initial begin
    cyc(1);
    chk("R1 oe in reset", pad_oe, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 stat after reset", stat, 1'b0);

    foreach (VEC[i]) begin
      {func_en, sync_mode, dir_out, gpio_out, gpio_dir, int_bclk} = VEC[i][7:2];
      #1;
      chk("R2/R5/R9 table oe", pad_oe, VEC[i][1]);
      chk("R2/R5/R9 table pad", pad_o, VEC[i][0]);
      if (func_en && !sync_mode && dir_out) chk("R2 rx_bclk", rx_bclk, int_bclk);
      cyc(1);
    end

    // R3/R4 clock input, edge strobes
    func_en = 1; sync_mode = 0; dir_out = 0; pad = 0;
    cyc(4);
    pad = 1;
    cyc(1);
    chk("R4 no rise after 1 edge", rise, 1'b0);
    chk("R3 rx_bclk lag 1", rx_bclk, 1'b0);
    cyc(1);
    chk("R4 rise after 2 edges", rise, 1'b1);
    chk("R3 rx_bclk after 2", rx_bclk, 1'b1);
    cyc(1);
    chk("R4 rise one cycle", rise, 1'b0);
    pad = 0;
    cyc(2);
    chk("R4 fall after 2 edges", fall, 1'b1);
    chk("R4 rise quiet on fall", rise, 1'b0);
    cyc(1);
    chk("R4 fall one cycle", fall, 1'b0);
    // R4 no strobes in GPIO role
    func_en = 0; pad = 1;
    cyc(2);
    chk("R4 no rise gpio role", rise, 1'b0);
    chk("R9 gpio_in sync", gpio_in, 1'b1);

    // R5/R6 output flag
    func_en = 1; sync_mode = 1; dir_out = 1; flag_ctrl = 1;
    cyc(2);
    chk("R6 hold without fs", pad_o, 1'b0);
    fs = 1;
    cyc(1);
    fs = 0; flag_ctrl = 0;
    #1;
    chk("R6 load at fs", pad_o, 1'b1);
    chk("R5 oe flag out", pad_oe, 1'b1);
    cyc(3);
    chk("R6 hold after fs", pad_o, 1'b1);
    fs = 1;
    cyc(1);
    fs = 0;
    chk("R6 clear at fs", pad_o, 1'b0);

    // R7 input flag, normal mode
    dir_out = 0; net_mode = 0; pad = 1;
    cyc(3);
    slot = 1;
    cyc(1);
    slot = 0;
    chk("R7 slot ignored", stat, 1'b0);
    fs = 1;
    cyc(1);
    fs = 0;
    chk("R7 capture at fs", stat, 1'b1);
    chk("R7 oe low", pad_oe, 1'b0);

    // R8 network mode
    net_mode = 1; pad = 0;
    cyc(3);
    fs = 1;
    cyc(1);
    fs = 0;
    chk("R8 fs ignored", stat, 1'b1);
    slot = 1;
    cyc(1);
    slot = 0;
    chk("R8 capture at slot", stat, 1'b0);

    // R1 reset clears status and flag
    pad = 1; slot = 1;
    cyc(3);
    slot = 0;
    chk("R8 capture high", stat, 1'b1);
    rst_n = 0;
    #1;
    chk("R1 oe in reset again", pad_oe, 1'b0);
    chk("R1 stat cleared", stat, 1'b0);
    cyc(1);
    rst_n = 1;
    finished = 1;
  end

  initial begin
    int wd = 0;
    while (!finished && wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule